// File: doc/BRIEF.md
# Seven-Level Level-Shifted Carrier PWM Generator

This block drives the six gates of one phase leg of an asymmetric seven-level bridge. The leg holds two capacitors, the upper charged to twice the voltage of the lower, so it can present -3 to +3 units of the lower capacitor voltage. A signed modulation sample arrives every clock. The block captures it only when the shared triangle carrier reaches a turning point. It compares the captured value against six identical triangles, each shifted one span above the one below. The number of triangles the sample exceeds selects one of seven output levels.

The selected level maps to the states of three switch pairs. A pair state of 1 turns on the first switch of the pair (S1, S3, S5). A pair state of 0 turns on the second switch (S2, S4, S6). The S5/S6 pair follows only the sign of the output, so it changes at the fundamental frequency. Every change of pair state passes through a blanking interval, set at run time, in which both switches of that pair are off. The selected level index is also provided for neighbouring control logic.

Top module: `pwm7_cd_gen`

## Requirements
- R1: A triangle counter steps by one once every DIV clocks and runs between 0 and SPAN. Carrier k (k = 0..5) equals (k-3)*SPAN plus the counter, so the six carriers cover -3*SPAN to +3*SPAN with a common phase.
- R2: The modulation sample is captured only on a counter step taken while the counter sits at 0 or at SPAN. At any other time a change of the sample has no effect on the level.
- R3: The level is the count of carriers that lie strictly below the captured sample. It is registered and presented on `level_idx` as 1 (lowest, -3) to 7 (highest, +3).
- R4: Pair states {S5S6, S3S4, S1S2} per signed level: +3 = 0,1,1; +2 = 0,0,1; +1 = 0,1,0; 0 = 1,1,1; -1 = 1,0,1; -2 = 1,1,0; -3 = 1,0,0.
- R5: The S5/S6 pair keeps S6 on for every positive level and S5 on for zero and every negative level.
- R6: The two switches of a pair are never on in the same cycle.
- R7: When a pair's wanted state changes, both of its switches are off for `dead_cyc` clocks before the new state is applied. A zero value switches at once. A further change during the off window restarts the window.
- R8: A synchronous reset turns every gate off and sets `level_idx` to 4. The gates stay off until the first captured sample has passed through the level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_smp | input | SMP_W | Signed modulation sample |
| dead_cyc | input | DT_W | Blanking length in clocks |
| level_idx | output | 3 | Selected level, 1..7 |
| sw_a | output | 3 | First switch of pairs 1..3 (S1, S3, S5) |
| sw_b | output | 3 | Second switch of pairs 1..3 (S2, S4, S6) |

## Verification
The delicate coincidence is a new pair state that arrives while that pair is still blanked from the previous change. The blanking must restart rather than expire early or let the stale state through. The bench provokes this by holding a sample just below the top of one carrier with a long blanking, so that the carrier crosses the sample twice within a few clocks. A behavioural reference steps in lockstep and judges every gate and the level on every clock.

// File: rtl/pwm7_pkg.sv
package pwm7_pkg;
   localparam int NCAR  = 6;
   localparam int NPAIR = 3;
   localparam int MID   = 3;

   // level index 0..6 (signed level = idx-3) -> pair states {p3,p2,p1}
   // a pair state of 1 turns the first switch of the pair on
   function automatic logic [NPAIR-1:0] pair_want(input logic [2:0] idx);
      case (idx)
         3'd6:    return 3'b011;
         3'd5:    return 3'b001;
         3'd4:    return 3'b010;
         3'd3:    return 3'b111;
         3'd2:    return 3'b101;
         3'd1:    return 3'b110;
         default: return 3'b100;
      endcase
   endfunction
endpackage

// File: rtl/pwm7_carrier.sv
module pwm7_carrier #(
   parameter int DIV  = 25,
   parameter int SPAN = 250,
   parameter int TW   = $clog2(SPAN + 1)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [TW-1:0] tri_o,
   output logic          turn_o
);
   logic step;
   logic up_q;

   generate
      if (DIV == 1) begin : g_nodiv
         assign step = 1'b1;
      end else begin : g_div
         localparam int DVW = $clog2(DIV);
         logic [DVW-1:0] div_q;
         assign step = (div_q == DVW'(DIV - 1));
         always_ff @(posedge clk) begin
            if (rst)       div_q <= '0;
            else if (step) div_q <= '0;
            else           div_q <= div_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         tri_o <= '0;
         up_q  <= 1'b1;
      end else if (step) begin
         if (up_q) begin
            tri_o <= tri_o + 1'b1;
            if (tri_o == TW'(SPAN - 1)) up_q <= 1'b0;
         end else begin
            tri_o <= tri_o - 1'b1;
            if (tri_o == TW'(1)) up_q <= 1'b1;
         end
      end
   end

   assign turn_o = step && ((tri_o == '0) || (tri_o == TW'(SPAN)));

   p_tri_range_r1: assert property (@(posedge clk) disable iff (rst)
      tri_o <= TW'(SPAN));
   p_step_size_r1: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(tri_o));
endmodule

// File: rtl/pwm7_slicer.sv
module pwm7_slicer
   import pwm7_pkg::*;
#(
   parameter int SMP_W = 12,
   parameter int SPAN  = 250,
   parameter int TW    = $clog2(SPAN + 1)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [SMP_W-1:0] smp_i,
   input  logic [TW-1:0]           tri_i,
   input  logic                    turn_i,
   output logic [2:0]              lvl_o,
   output logic                    ok_o
);
   logic signed [SMP_W-1:0] hold_q;
   logic                    valid_q;
   logic [NCAR-1:0]         above;
   logic [2:0]              cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q  <= '0;
         valid_q <= 1'b0;
      end else if (turn_i) begin
         hold_q  <= smp_i;
         valid_q <= 1'b1;
      end
   end

   for (genvar k = 0; k < NCAR; k++) begin : g_cmp
      assign above[k] = (int'(hold_q) > ((k - MID) * SPAN + int'(tri_i)));
   end

   always_comb begin
      cnt = '0;
      for (int k = 0; k < NCAR; k++) cnt = cnt + 3'(above[k]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_o <= 3'(MID);
         ok_o  <= 1'b0;
      end else begin
         lvl_o <= cnt;
         ok_o  <= valid_q;
      end
   end

   p_hold_only_at_turn_r2: assert property (@(posedge clk) disable iff (rst)
      !turn_i |=> $stable(hold_q));
   p_level_range_r3: assert property (@(posedge clk) disable iff (rst)
      lvl_o <= 3'd6);
endmodule

// File: rtl/pwm7_deadband.sv
module pwm7_deadband #(
   parameter int DT_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en_i,
   input  logic            want_i,
   input  logic [DT_W-1:0] dead_i,
   output logic            hi_o,
   output logic            lo_o
);
   logic            cur_q;
   logic            act_q;
   logic [DT_W-1:0] dt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q <= 1'b0;
         dt_q  <= '0;
         act_q <= 1'b0;
      end else begin
         act_q <= en_i;
         if (!en_i) begin
            cur_q <= want_i;
            dt_q  <= '0;
         end else if (want_i != cur_q) begin
            cur_q <= want_i;
            dt_q  <= dead_i;
         end else if (dt_q != '0) begin
            dt_q  <= dt_q - 1'b1;
         end
      end
   end

   assign hi_o = act_q && (dt_q == '0) && cur_q;
   assign lo_o = act_q && (dt_q == '0) && !cur_q;

   p_never_both_r6: assert property (@(posedge clk) disable iff (rst)
      !(hi_o && lo_o));
   p_gap_up_r7: assert property (@(posedge clk) disable iff (rst)
      (hi_o && $past(lo_o)) |-> ($past(dead_i) == '0));
   p_gap_down_r7: assert property (@(posedge clk) disable iff (rst)
      (lo_o && $past(hi_o)) |-> ($past(dead_i) == '0));
   p_off_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> (!hi_o && !lo_o));
endmodule

// File: rtl/pwm7_cd_gen.sv
module pwm7_cd_gen
   import pwm7_pkg::*;
#(
   parameter int SMP_W = 12,
   parameter int DIV   = 25,
   parameter int SPAN  = 250,
   parameter int DT_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [SMP_W-1:0] mod_smp,
   input  logic [DT_W-1:0]         dead_cyc,
   output logic [2:0]              level_idx,
   output logic [NPAIR-1:0]        sw_a,
   output logic [NPAIR-1:0]        sw_b
);
   localparam int TW = $clog2(SPAN + 1);

   initial begin
      if (DIV < 1)  $error("DIV must be at least 1");
      if (SPAN < 2) $error("SPAN must be at least 2");
      if (MID * SPAN >= (1 << (SMP_W - 1))) $error("SMP_W too narrow for 3*SPAN");
      if (DT_W < 1) $error("DT_W must be at least 1");
   end

   logic [TW-1:0]    tri_w;
   logic             turn_w;
   logic [2:0]       lvl_w;
   logic             ok_w;
   logic [NPAIR-1:0] want_w;

   pwm7_carrier #(.DIV(DIV), .SPAN(SPAN), .TW(TW)) u_car (
      .clk(clk), .rst(rst), .tri_o(tri_w), .turn_o(turn_w));

   pwm7_slicer #(.SMP_W(SMP_W), .SPAN(SPAN), .TW(TW)) u_slc (
      .clk(clk), .rst(rst), .smp_i(mod_smp), .tri_i(tri_w), .turn_i(turn_w),
      .lvl_o(lvl_w), .ok_o(ok_w));

   assign want_w    = pair_want(lvl_w);
   assign level_idx = lvl_w + 3'd1;

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      pwm7_deadband #(.DT_W(DT_W)) u_db (
         .clk(clk), .rst(rst), .en_i(ok_w), .want_i(want_w[p]),
         .dead_i(dead_cyc), .hi_o(sw_a[p]), .lo_o(sw_b[p]));
   end

   p_sign_pair_r5: assert property (@(posedge clk) disable iff (rst)
      (level_idx > 3'd4) |-> !want_w[2]);
   p_reset_level_r8: assert property (@(posedge clk)
      rst |=> (level_idx == 3'd4 && sw_a == '0 && sw_b == '0));
endmodule

// File: tb/pwm7_cd_gen_bench.sv
module pwm7_cd_gen_bench;
   localparam int SMP_W = 8;
   localparam int DIV   = 2;
   localparam int SPAN  = 8;
   localparam int DT_W  = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic signed [SMP_W-1:0] mod_smp = '0;
   logic [DT_W-1:0] dead_cyc = 4'd3;
   logic [2:0] level_idx;
   logic [2:0] sw_a, sw_b;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   pwm7_cd_gen #(.SMP_W(SMP_W), .DIV(DIV), .SPAN(SPAN), .DT_W(DT_W)) u_pwm7_cd_gen (
      .clk(clk), .rst(rst), .mod_smp(mod_smp), .dead_cyc(dead_cyc),
      .level_idx(level_idx), .sw_a(sw_a), .sw_b(sw_b));

   // behavioural reference
   int m_div = 0, m_tri = 0, m_hold = 0, m_lvl = 3;
   bit m_up = 1, m_valid = 0, m_ok = 0;
   bit m_cur [3];
   int m_dt [3];
   bit m_act [3];

   function automatic bit [2:0] ref_map(int s);
      case (s)
         3:  return 3'b011;
         2:  return 3'b001;
         1:  return 3'b010;
         0:  return 3'b111;
         -1: return 3'b101;
         -2: return 3'b110;
         default: return 3'b100;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_div = 0; m_tri = 0; m_up = 1; m_hold = 0; m_valid = 0;
         m_lvl = 3; m_ok = 0;
         for (int i = 0; i < 3; i++) begin m_cur[i] = 0; m_dt[i] = 0; m_act[i] = 0; end
      end else begin
         bit stp, cap;
         bit [2:0] w;
         int n;
         stp = (m_div == DIV - 1);
         cap = stp && (m_tri == 0 || m_tri == SPAN);
         w = ref_map(m_lvl - 3);
         for (int i = 0; i < 3; i++) begin
            if (!m_ok) begin m_cur[i] = w[i]; m_dt[i] = 0; end
            else if (w[i] != m_cur[i]) begin m_cur[i] = w[i]; m_dt[i] = int'(dead_cyc); end
            else if (m_dt[i] > 0) m_dt[i]--;
            m_act[i] = m_ok;
         end
         n = 0;
         for (int k = 0; k < 6; k++) if (m_hold > (k - 3) * SPAN + m_tri) n++;
         m_ok = m_valid;
         m_lvl = n;
         if (cap) begin m_hold = int'(mod_smp); m_valid = 1; end
         if (stp) begin
            if (m_up) begin m_tri++; if (m_tri == SPAN) m_up = 0; end
            else begin m_tri--; if (m_tri == 0) m_up = 1; end
         end
         m_div = stp ? 0 : m_div + 1;
      end
   end

   task automatic compare();
      bit [2:0] ea, eb;
      for (int i = 0; i < 3; i++) begin
         ea[i] = m_act[i] && m_dt[i] == 0 && m_cur[i];
         eb[i] = m_act[i] && m_dt[i] == 0 && !m_cur[i];
      end
      checks++;
      if (level_idx !== 3'(m_lvl + 1)) begin
         errors++;
         $display("FAIL R1 R3 level_idx actual %0d expected %0d", level_idx, m_lvl + 1);
      end
      checks++;
      if (sw_a !== ea || sw_b !== eb) begin
         errors++;
         $display("FAIL R4 R7 gates actual a=%b b=%b expected a=%b b=%b", sw_a, sw_b, ea, eb);
      end
      checks++;
      if ((sw_a & sw_b) !== 3'b000) begin
         errors++;
         $display("FAIL R6 overlap actual %b expected 000", sw_a & sw_b);
      end
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cycles++;
         compare();
      end
   endtask

   task automatic expect_val(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   initial begin
      #600000;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      run(4);
      // R8: reset state
      expect_val("R8 reset level", int'(level_idx), 4);
      expect_val("R8 reset gates", int'({sw_a, sw_b}), 0);
      rst = 1'b0;
      run(1);
      expect_val("R8 gates off before capture", int'({sw_a, sw_b}), 0);
      run(100);
      // ramp across the full range
      for (int v = -30; v <= 30; v++) begin
         mod_smp = 8'(v);
         run(16);
      end
      // immediate switching
      dead_cyc = 4'd0;
      mod_smp = 8'sd5;
      run(200);
      // long blanking with crossings near a carrier peak (restart case, R7)
      dead_cyc = 4'd15;
      mod_smp = 8'sd7;
      run(300);
      mod_smp = -8'sd9;
      run(300);
      // R2: mid-period change is ignored
      dead_cyc = 4'd2;
      mod_smp = 8'sd100;
      run(100);
      expect_val("R5 S6 on at +3", int'({sw_a[2], sw_b[2]}), 1);
      while (!(m_tri == 4 && m_up && m_div == 0)) run(1);
      mod_smp = -8'sd100;
      run(3);
      expect_val("R2 level held mid period", int'(level_idx), 7);
      run(70);
      expect_val("R2 level after turn", int'(level_idx), 1);
      expect_val("R5 S5 on at -3", int'({sw_a[2], sw_b[2]}), 2);
      // staircase over each level
      for (int s = -3; s <= 3; s++) begin
         mod_smp = 8'(s * SPAN + (s >= 0 ? 4 : -4));
         run(80);
      end
      // reset mid run
      rst = 1'b1;
      run(3);
      expect_val("R8 reset again level", int'(level_idx), 4);
      rst = 1'b0;
      mod_smp = 8'sd20;
      run(1);
      expect_val("R8 off after release", int'({sw_a, sw_b}), 0);
      run(200);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule